// File: doc/BRIEF.md
# Interrupting GPIO Pin Bank

This block controls a bank of general-purpose pins through a small 32-bit register bus. Each pin has its own configuration word. The word sets the output enable, the input enable, the output-buffer enable, the interrupt enable and a 3-bit trigger selector.

Three shared words serve all pins:
- the synchronised input levels, one bit per pin;
- the output data, one bit per pin;
- a sticky interrupt status, one bit per pin, cleared by writing 1.

A single registered interrupt line is raised while any status bit is set. Software reads the status word, writes 1 to the bits it has serviced, and drives pins through the output data word.

Every pin input passes through a two-flop synchroniser before it is read or detected. Edge triggers compare the synchronised level with the sample taken one cycle earlier. Level triggers set the status bit again on every cycle the active level is present.

Bus timing:
- A bus access is one cycle with `busSel` high.
- Writes take effect at that clock edge.
- Read data appears on `busRdata` after that edge and holds until the next read.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every configuration word, the output data, the status word, `busRdata`, `pinOe` and `irqOut` are zero.
- R2: Configuration word of pin i is at byte address 4*i. Bits 7:0 are stored and read back. Bits 31:8 read as zero.
- R3: In a configuration word, bit 0 is output enable, bit 1 is input enable and bit 2 is output-buffer enable. `pinOe[i]` is high exactly when bits 0 and 2 are set and bit 1 is clear.
- R4: The output data word at 0x88 is read/write with one bit per pin and drives `pinOut`. Bits at or above the pin count read zero.
- R5: The input word at 0x84 returns the synchronised pin level for pins whose input-enable bit (bit 1) is set, and zero for the other pins. A pin change first shows in a read captured on the third clock edge after the change.
- R6: The trigger field is bits 7:5 and bit 3 is the interrupt enable. Code 000 (level high) and code 001 (level low) set the status bit on every cycle the active level holds, including the cycle right after a clear.
- R7: Code 010 sets status on a synchronised rising edge, code 011 on a falling edge, and code 100 on either edge.
- R8: Trigger codes 101, 110 and 111 never set status. A pin whose interrupt-enable bit 3 is clear never sets status.
- R9: The status word at 0x80 is sticky. Writing 1 to a bit clears only that bit. If a set and a clear reach the same bit in one cycle, the set wins.
- R10: `irqOut` is high in the cycle after any status bit is high and low in the cycle after the status word is zero.
- R11: These accesses read zero and their writes change nothing:
  - configuration slots at or above the pin count;
  - any offset not listed above;
  - any address with nonzero low two bits;
  - writes to 0x84.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| pinIn | input | PINS | Raw pin levels, asynchronous |
| pinOut | output | PINS | Output data to the pads |
| pinOe | output | PINS | Per-pin output drive enable |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bench targets the following corner cases:
- **Level trigger held during a clear.** The status bit must stay set. A design where the clear beats the set would drop an interrupt that is still pending.
- **Edge of the wrong polarity.** It must leave status quiet. A design that mixes up the 010, 011 and 100 decodes would raise spurious interrupts or miss real ones.
- **Reserved codes and a cleared interrupt enable.** Both are toggled and must set nothing.
- **Two pending bits, one cleared.** Only that one bit may fall. A design that clears the whole word would drop the other interrupt.
- **Synchroniser latency and input-enable masking.** These are checked cycle by cycle against a behavioural model, as is the one-cycle lag of the interrupt line.
- **Misaligned, unmapped and read-only addresses.** They must read zero and absorb writes without changing any state.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int MAX_PINS = 32;
  localparam int CFG_W    = 8;
  localparam int IDX_W    = 5;

  // configuration word bit positions
  localparam int CB_OUT_EN = 0;
  localparam int CB_IN_EN  = 1;
  localparam int CB_BUF_EN = 2;
  localparam int CB_INT_EN = 3;
  localparam int CB_TRIG_LO = 5;

  typedef enum logic [2:0] {
    TRIG_LVL_HIGH = 3'b000,
    TRIG_LVL_LOW  = 3'b001,
    TRIG_RISE     = 3'b010,
    TRIG_FALL     = 3'b011,
    TRIG_BOTH     = 3'b100
  } trigCode_e;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CFG,
    RD_STS,
    RD_IN,
    RD_OUT
  } rdSel_e;

  typedef struct packed {
    logic             cfgWr;
    logic             outWr;
    logic             stsClr;
    logic             rdEn;
    rdSel_e           rdSel;
    logic [IDX_W-1:0] pinIdx;
  } bankStrobe_t;
endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
  import pinbank_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output bankStrobe_t       strobe
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] STS_WORD = WORD_W'(32);
  localparam logic [WORD_W-1:0] IN_WORD  = WORD_W'(33);
  localparam logic [WORD_W-1:0] OUT_WORD = WORD_W'(34);

  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_NONE;
    if (busSel) begin
      strobe.rdEn = !busWrite;
      if (aligned) begin
        if (int'(word) < PINS) begin
          strobe.pinIdx = word[IDX_W-1:0];
          strobe.cfgWr  = busWrite;
          if (!busWrite) strobe.rdSel = RD_CFG;
        end else if (word == STS_WORD) begin
          strobe.stsClr = busWrite;
          if (!busWrite) strobe.rdSel = RD_STS;
        end else if (word == IN_WORD) begin
          if (!busWrite) strobe.rdSel = RD_IN;
        end else if (word == OUT_WORD) begin
          strobe.outWr = busWrite;
          if (!busWrite) strobe.rdSel = RD_OUT;
        end
      end
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.cfgWr, strobe.outWr, strobe.stsClr, strobe.rdEn})) else $error("one action"); // R11
endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stg <= '0;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/pinbank_datapath.sv
module pinbank_datapath
  import pinbank_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strobe,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PINS-1:0]   syncIn,
  output logic [DATA_W-1:0] rdata,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  output logic              irqOut
);
  logic [CFG_W-1:0]  cfgReg [PINS];
  logic [PINS-1:0]   outReg;
  logic [PINS-1:0]   stsReg;
  logic [PINS-1:0]   prevIn;
  logic [PINS-1:0]   hit;
  logic [PINS-1:0]   inEnVec;
  logic [PINS-1:0]   clrMask;
  logic [DATA_W-1:0] rdNext;
  logic [DATA_W-1:0] rdReg;
  logic              irqReg;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [2:0] trig;
    logic       det;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cfgReg[i] <= '0;
      else if (strobe.cfgWr && strobe.pinIdx == IDX_W'(i)) cfgReg[i] <= wdata[CFG_W-1:0];
    end

    assign trig       = cfgReg[i][CB_TRIG_LO +: 3];
    assign inEnVec[i] = cfgReg[i][CB_IN_EN];
    assign pinOe[i]   = cfgReg[i][CB_OUT_EN] & cfgReg[i][CB_BUF_EN] & ~cfgReg[i][CB_IN_EN];

    always_comb begin
      case (trig)
        TRIG_LVL_HIGH: det = syncIn[i];
        TRIG_LVL_LOW:  det = ~syncIn[i];
        TRIG_RISE:     det = syncIn[i] & ~prevIn[i];
        TRIG_FALL:     det = ~syncIn[i] & prevIn[i];
        TRIG_BOTH:     det = syncIn[i] ^ prevIn[i];
        default:       det = 1'b0;
      endcase
    end
    assign hit[i] = det & cfgReg[i][CB_INT_EN];

    AST_STS_NEEDS_INTEN: assert property (@(posedge clk) disable iff (!rstN)
      $rose(stsReg[i]) |-> $past(cfgReg[i][CB_INT_EN])) else $error("status without enable"); // R8
    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      $rose(stsReg[i]) |-> ($past(cfgReg[i][CB_TRIG_LO +: 3]) <= 3'd4)) else $error("reserved trigger"); // R8
    AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (stsReg[i] && !clrMask[i]) |=> stsReg[i]) else $error("status lost"); // R9
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (cfgReg[i][CB_INT_EN] && cfgReg[i][CB_TRIG_LO +: 3] == 3'b000 && syncIn[i]) |=> stsReg[i]) else $error("level dropped"); // R6
  end

  assign clrMask = strobe.stsClr ? wdata[PINS-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
      stsReg <= '0;
      prevIn <= '0;
      irqReg <= 1'b0;
    end else begin
      if (strobe.outWr) outReg <= wdata[PINS-1:0];
      stsReg <= (stsReg & ~clrMask) | hit;
      prevIn <= syncIn;
      irqReg <= |stsReg;
    end
  end

  always_comb begin
    rdNext = '0;
    case (strobe.rdSel)
      RD_CFG: begin
        for (int k = 0; k < PINS; k++)
          if (strobe.pinIdx == IDX_W'(k)) rdNext[CFG_W-1:0] = cfgReg[k];
      end
      RD_STS:  rdNext[PINS-1:0] = stsReg;
      RD_IN:   rdNext[PINS-1:0] = syncIn & inEnVec;
      RD_OUT:  rdNext[PINS-1:0] = outReg;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdReg <= '0;
    else if (strobe.rdEn) rdReg <= rdNext;
  end

  assign rdata  = rdReg;
  assign pinOut = outReg;
  assign irqOut = irqReg;

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stsReg == '0) |=> !irqOut) else $error("irq without status"); // R10
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (stsReg != '0) |=> irqOut) else $error("irq missing"); // R10
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  output logic              irqOut
);
  bankStrobe_t     strobe;
  logic [PINS-1:0] syncIn;

  pinbank_decode #(.PINS(PINS), .ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .strobe(strobe)
  );

  pinbank_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din(pinIn), .dout(syncIn)
  );

  pinbank_datapath #(.PINS(PINS), .DATA_W(32)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(busWdata),
    .syncIn(syncIn), .rdata(busRdata), .pinOut(pinOut), .pinOe(pinOe),
    .irqOut(irqOut)
  );
endmodule

// File: tb/pinbank_ctrl_test.sv
`timescale 1ns/1ps
module pinbank_ctrl_test;
  localparam int PINS = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busSel = 1'b0;
  logic              busWrite = 1'b0;
  logic [7:0]        busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic [PINS-1:0]   pinIn = '0;
  logic [PINS-1:0]   pinOut;
  logic [PINS-1:0]   pinOe;
  logic              irqOut;

  int    vectors = 0;
  int    fails = 0;
  bit    running = 0;
  bit    done = 0;
  string phaseTag = "R1";

  always #4 clk = ~clk;

  pinbank_ctrl #(.PINS(PINS), .ADDR_W(8), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  // behavioural reference model
  logic [7:0]      mCfg [PINS];
  logic [PINS-1:0] mOut, mSts, mS1, mS2, mPrev, mHit, mClr, mInEn;
  logic            mIrq;
  logic [31:0]     mRd;

  function automatic bit trigHit(input logic [2:0] t, input logic s, input logic p);
    if (t == 3'd0) return s;
    if (t == 3'd1) return !s;
    if (t == 3'd2) return s && !p;
    if (t == 3'd3) return !s && p;
    if (t == 3'd4) return s != p;
    return 1'b0;
  endfunction

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    int w;
    logic [31:0] r;
    w = int'(a[7:2]);
    r = '0;
    if (a[1:0] != 2'b00) return '0;
    if (w < PINS) r[7:0] = mCfg[w];
    else if (w == 32) r[PINS-1:0] = mSts;
    else if (w == 33) r[PINS-1:0] = mS2 & mInEn;
    else if (w == 34) r[PINS-1:0] = mOut;
    return r;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PINS; i++) mCfg[i] = '0;
      mOut = '0; mSts = '0; mS1 = '0; mS2 = '0; mPrev = '0; mIrq = 0; mRd = '0;
    end else begin
      for (int i = 0; i < PINS; i++) begin
        mInEn[i] = mCfg[i][1];
        mHit[i]  = mCfg[i][3] && trigHit(mCfg[i][7:5], mS2[i], mPrev[i]);
      end
      if (busSel && !busWrite) mRd = modelRead(busAddr);
      mClr = '0;
      if (busSel && busWrite && busAddr == 8'h80) mClr = busWdata[PINS-1:0];
      mIrq = (mSts != 0);
      mSts = (mSts & ~mClr) | mHit;
      mPrev = mS2; mS2 = mS1; mS1 = pinIn;
      if (busSel && busWrite && busAddr[1:0] == 2'b00) begin
        if (int'(busAddr[7:2]) < PINS) mCfg[busAddr[7:2]] = busWdata[7:0];
        else if (busAddr == 8'h88) mOut = busWdata[PINS-1:0];
      end
      for (int i = 0; i < PINS; i++) mInEn[i] = mCfg[i][1];
    end
  end

  function automatic logic [PINS-1:0] modelOe();
    logic [PINS-1:0] o;
    for (int i = 0; i < PINS; i++) o[i] = mCfg[i][0] && mCfg[i][2] && !mCfg[i][1];
    return o;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (rstN && running) begin
      chk({phaseTag, " busRdata"}, busRdata, mRd);
      chk("R3 pinOe", 32'(pinOe), 32'(modelOe()));
      chk("R4 pinOut", 32'(pinOut), 32'(mOut));
      chk("R10 irqOut", 32'(irqOut), 32'(mIrq));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic rdExp(input logic [7:0] a, input logic [31:0] exp, input string tag);
    busSel = 1; busWrite = 0; busAddr = a;
    @(negedge clk);
    busSel = 0;
    chk(tag, busRdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    chk("R1 irqOut", 32'(irqOut), 0);
    chk("R1 pinOe", 32'(pinOe), 0);
    chk("R1 busRdata", busRdata, 0);
    running = 1;
    rdExp(8'h80, 0, "R1 status");
    rdExp(8'h84, 0, "R1 input");
    rdExp(8'h88, 0, "R1 output");
    rdExp(8'h00, 0, "R1 cfg0");

    phaseTag = "R2";
    wr(8'h0C, 32'h1234_56A5);
    rdExp(8'h0C, 32'h0000_00A5, "R2 cfg3 low byte");
    wr(8'h2C, 32'h45);
    rdExp(8'h2C, 32'h45, "R2 last pin cfg");

    phaseTag = "R11";
    wr(8'h30, 32'hFF);
    rdExp(8'h30, 0, "R11 slot above pin count");
    rdExp(8'h7C, 0, "R11 unmapped");
    rdExp(8'h8C, 0, "R11 unmapped");

    phaseTag = "R3";
    wr(8'h00, 32'h05);
    chk("R3 out+buf drives", 32'(pinOe[0]), 1);
    wr(8'h04, 32'h07);
    chk("R3 input wins", 32'(pinOe[1]), 0);
    wr(8'h08, 32'h01);
    chk("R3 no buffer", 32'(pinOe[2]), 0);

    phaseTag = "R4";
    wr(8'h88, 32'hFFFF_FFFF);
    rdExp(8'h88, 32'h0000_0FFF, "R4 output width");
    chk("R4 pinOut", 32'(pinOut), 32'hFFF);
    phaseTag = "R11";
    wr(8'h89, 32'h0);
    rdExp(8'h88, 32'h0000_0FFF, "R11 misaligned write ignored");
    rdExp(8'h81, 0, "R11 misaligned read");
    wr(8'h84, 32'hFFFF_FFFF);
    rdExp(8'h84, 0, "R11 input word read-only");
    phaseTag = "R4";
    wr(8'h88, 32'h0A5);
    chk("R4 pinOut", 32'(pinOut), 32'h0A5);

    phaseTag = "R5";
    wr(8'h10, 32'h02);
    pinIn = 12'h030;
    rdExp(8'h84, 0, "R5 sync stage 1");
    rdExp(8'h84, 0, "R5 sync stage 2");
    rdExp(8'h84, 32'h010, "R5 masked by input enable");

    phaseTag = "R6";
    wr(8'h18, 32'h0A);
    pinIn[6] = 1;
    idle(4);
    rdExp(8'h80, 32'h40, "R6 level high");
    chk("R10 irq up", 32'(irqOut), 1);
    wr(8'h80, 32'h40);
    rdExp(8'h80, 32'h40, "R9 set wins over clear");
    pinIn[6] = 0;
    idle(4);
    wr(8'h80, 32'h40);
    rdExp(8'h80, 0, "R9 cleared");
    idle(2);
    chk("R10 irq down", 32'(irqOut), 0);
    wr(8'h1C, 32'h2A);
    idle(2);
    rdExp(8'h80, 32'h80, "R6 level low");
    pinIn[7] = 1;
    idle(4);
    wr(8'h80, 32'h80);
    rdExp(8'h80, 0, "R6 level low released");

    phaseTag = "R7";
    wr(8'h20, 32'h4A);
    pinIn[8] = 1;
    idle(4);
    rdExp(8'h80, 32'h100, "R7 rising");
    wr(8'h80, 32'h100);
    pinIn[8] = 0;
    idle(4);
    rdExp(8'h80, 0, "R7 rising ignores fall");
    wr(8'h24, 32'h6A);
    pinIn[9] = 1;
    idle(4);
    rdExp(8'h80, 0, "R7 falling ignores rise");
    pinIn[9] = 0;
    idle(4);
    rdExp(8'h80, 32'h200, "R7 falling");
    wr(8'h80, 32'h200);
    wr(8'h28, 32'h8A);
    pinIn[10] = 1;
    idle(4);
    rdExp(8'h80, 32'h400, "R7 both, rise");
    wr(8'h80, 32'h400);
    pinIn[10] = 0;
    idle(4);
    rdExp(8'h80, 32'h400, "R7 both, fall");
    wr(8'h80, 32'h400);
    rdExp(8'h80, 0, "R7 both cleared");

    phaseTag = "R8";
    wr(8'h2C, 32'hAA);
    pinIn[11] = 1;
    idle(4);
    pinIn[11] = 0;
    idle(4);
    rdExp(8'h80, 0, "R8 reserved code");
    wr(8'h2C, 32'hEA);
    pinIn[11] = 1;
    idle(4);
    rdExp(8'h80, 0, "R8 reserved code 111");
    wr(8'h0C, 32'h02);
    pinIn[3] = 1;
    idle(4);
    rdExp(8'h80, 0, "R8 interrupt disabled");

    phaseTag = "R9";
    pinIn[8] = 1;
    pinIn[10] = 1;
    idle(4);
    rdExp(8'h80, 32'h500, "R9 two pending");
    chk("R10 irq with two pending", 32'(irqOut), 1);
    wr(8'h80, 32'h100);
    rdExp(8'h80, 32'h400, "R9 single-bit clear");
    wr(8'h80, 32'h400);
    rdExp(8'h80, 0, "R9 all clear");
    idle(2);
    chk("R10 irq low", 32'(irqOut), 0);

    done = 1;
    running = 0;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule